// File: doc/BRIEF.md
# Reference Clock Pre-Divider Chain

The block turns one reference clock into the slower tick stream that a downstream digital PLL locks to. It runs on a fast sampling clock. The reference level arrives on `ref_in`, and each rising edge of the reference is one input tick.

The ticks pass through up to two stages. The first is an optional high-frequency divider that divides by 4 or by 5. The second is chosen by two static enables. One picks a programmable counter that divides by the stored factor plus one. The other picks a fixed stage that divides down to 8 kHz, using a ratio taken from the required-frequency code. When both enables are clear, the second stage is bypassed.

When the frequency code marks a 2, 4 or 8 kHz reference, the whole chain is bypassed. In that case each output pulse marks a reference edge, and a flag chooses which edge. The output `div_ce` is a one-cycle pulse for each divided tick. It appears one sampling-clock cycle after the edge where the new reference level is first seen.

Top module: `prediv_chain`

## Requirements
- R1: `hf_sel` selects the first stage: 01 divides ticks by 4 and 10 divides by 5, so that after reset the first tick leaves that stage on the 4th or the 5th reference rise. 00 and 11 pass every tick through.
- R2: With `direct_en` set, the second stage divides first-stage ticks by `div_n`+1. The first first-stage tick after reset produces a pulse, and after that every (`div_n`+1)-th tick does.
- R3: A `div_n` of 0 makes the programmable stage pass every first-stage tick.
- R4: A new `div_n` takes effect only at the next terminal count of the counter already running. Pulses before that point keep the old spacing.
- R5: With `lock8k_en` set and `direct_en` clear, a pulse comes on every K-th first-stage tick, the first one on tick K. K is 193 for `freq_code` 0000 and 810 for `freq_code` 0010 (6.48 MHz). Codes 0001, 0011, 0100, 0101 and 0110 give 256, 2430, 3240, 4860 and 1620. Codes 0111 to 1100 give K = 1.
- R6: When both `direct_en` and `lock8k_en` are set, the programmable counter is used.
- R7: With both enables clear, every first-stage tick produces a pulse.
- R8: `freq_code` 1101, 1110 or 1111 (2, 4 and 8 kHz) bypasses both stages. `div_ce` then pulses after each rising reference edge when `low_inv` is 0, or after each falling edge when `low_inv` is 1.
- R9: `low_inv` has no effect when `freq_code` is below 1101.
- R10: While `rst_n` is low, `div_ce` is 0.
- R11: `div_ce` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock level, synchronous to clk |
| hf_sel | input | 2 | First-stage mode: 01 divide by 4, 10 divide by 5, else bypass |
| direct_en | input | 1 | Select the programmable divider |
| lock8k_en | input | 1 | Select the divide-to-8 kHz stage |
| div_n | input | NW | Programmable factor, equal to ratio minus one |
| freq_code | input | 4 | Required-frequency code |
| low_inv | input | 1 | Edge select for low-rate references |
| div_ce | output | 1 | One-cycle pulse per divided tick |

## Verification
On every cycle, the assertions check these properties:
- pulses are single-cycle and follow a reference edge;
- the programmable count stays within its factor;
- a zero factor, a bypassed second stage and an uninverted low-rate reference each produce a pulse on the cycle after the tick;
- the output is quiet during reset.

Only the bench scenarios can show the actual division ratios of each stage, the priority between the two enables, the deferred reload of a changed factor, the lock ratios from the table, and that the edge flag does nothing outside low-rate mode.

// File: rtl/prediv_chain.sv
module prediv_chain #(
  parameter int NW = 15,
  parameter int LW = 13,
  parameter bit HAS_HF = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic [1:0]    hf_sel,
  input  logic          direct_en,
  input  logic          lock8k_en,
  input  logic [NW-1:0] div_n,
  input  logic [3:0]    freq_code,
  input  logic          low_inv,
  output logic          div_ce
);

  localparam logic [3:0] LOW_FIRST = 4'd13;

  logic ref_q;
  logic rise, fall, tick1;
  logic low_rate;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_in;

  assign rise     = ref_in & ~ref_q;
  assign fall     = ~ref_in & ref_q;
  assign low_rate = freq_code >= LOW_FIRST;

  generate
    if (HAS_HF) begin : g_hf
      logic [2:0] hf_lim;
      logic [2:0] hf_cnt;
      assign hf_lim = (hf_sel == 2'b01) ? 3'd4 : (hf_sel == 2'b10) ? 3'd5 : 3'd0;
      assign tick1  = rise & ((hf_lim == 3'd0) | (hf_cnt == hf_lim - 3'd1));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hf_cnt <= '0;
        else if (rise && hf_lim != 3'd0)
          hf_cnt <= (hf_cnt == hf_lim - 3'd1) ? 3'd0 : hf_cnt + 3'd1;
    end else begin : g_nohf
      assign tick1 = rise;
    end
  endgenerate

  logic [NW-1:0] act_n, n_cnt;
  logic          n_tick;

  assign n_tick = tick1 & direct_en & (n_cnt == act_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_n <= '0;
      n_cnt <= '0;
    end else if (tick1 && direct_en) begin
      if (n_cnt == act_n) begin
        n_cnt <= '0;
        act_n <= div_n;
      end else begin
        n_cnt <= n_cnt + 1'b1;
      end
    end

  logic [LW-1:0] l_term, l_cnt;
  logic          l_tick;

  always_comb
    case (freq_code)
      4'd0:    l_term = LW'(192);
      4'd1:    l_term = LW'(255);
      4'd2:    l_term = LW'(809);
      4'd3:    l_term = LW'(2429);
      4'd4:    l_term = LW'(3239);
      4'd5:    l_term = LW'(4859);
      4'd6:    l_term = LW'(1619);
      default: l_term = '0;
    endcase

  assign l_tick = tick1 & (l_cnt == l_term);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) l_cnt <= '0;
    else if (tick1 && lock8k_en && !direct_en)
      l_cnt <= l_tick ? '0 : l_cnt + 1'b1;

  logic stage2, next_ce;
  assign stage2  = direct_en ? n_tick : (lock8k_en ? l_tick : tick1);
  assign next_ce = low_rate ? (low_inv ? fall : rise) : stage2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_ce <= 1'b0;
    else        div_ce <= next_ce;

  always @(posedge clk)
    if (!rst_n) assert_reset_idle_R10: assert (!div_ce);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    div_ce |=> !div_ce);

  assert_pulse_from_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_ce |-> $past(ref_in != ref_q));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    n_cnt <= act_n);

  assert_zero_factor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_rate && direct_en && act_n == '0 && tick1) |=> div_ce);

  assert_stage_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_rate && !direct_en && !lock8k_en && tick1) |=> div_ce);

  assert_low_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (low_rate && !low_inv && rise) |=> div_ce);

endmodule

// File: tb/prediv_chain_test.sv
module prediv_chain_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic [1:0]  hf_sel = 2'b00;
  logic        direct_en = 1'b0;
  logic        lock8k_en = 1'b0;
  logic [14:0] div_n = '0;
  logic [3:0]  freq_code = 4'd2;
  logic        low_inv = 1'b0;
  logic        div_ce;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prediv_chain uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .hf_sel(hf_sel),
    .direct_en(direct_en), .lock8k_en(lock8k_en), .div_n(div_n),
    .freq_code(freq_code), .low_inv(low_inv), .div_ce(div_ce)
  );

  task automatic check(input string req, input logic act, input logic exp, input int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at rise %0d: div_ce=%b expected %b", req, idx, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] hf, input logic de, input logic le,
                          input int n, input logic [3:0] fc, input logic inv);
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0;
    hf_sel = hf; direct_en = de; lock8k_en = le;
    div_n = 15'(n); freq_code = fc; low_inv = inv;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mode: 0 stage-2 bypass, 1 divide by k (first pulse on tick 1), 2 lock ratio k
  function automatic logic expect_pulse(input int i, input int h, input int mode, input int k);
    int j;
    if (i % h != 0) return 1'b0;
    j = i / h;
    case (mode)
      0:       return 1'b1;
      1:       return ((j - 1) % k) == 0;
      default: return (j % k) == 0;
    endcase
  endfunction

  task automatic run_case(input string req, input int nrise, input int h,
                          input int mode, input int k);
    for (int i = 1; i <= nrise; i++) begin
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk);
      check(req, div_ce, expect_pulse(i, h, mode, k), i);
      ref_in = 1'b0;
      @(negedge clk);
      check(req, div_ce, 1'b0, i);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R10", div_ce, 1'b0, 0);
  endtask

  task automatic test_stage_bypass();
    do_reset(2'b00, 0, 0, 7, 4'd2, 0); run_case("R7", 10, 1, 0, 1);
    do_reset(2'b11, 0, 0, 7, 4'd2, 0); run_case("R1", 10, 1, 0, 1);
  endtask

  task automatic test_hf();
    do_reset(2'b01, 0, 0, 0, 4'd2, 0); run_case("R1", 20, 4, 0, 1);
    do_reset(2'b10, 0, 0, 0, 4'd2, 0); run_case("R1", 20, 5, 0, 1);
  endtask

  task automatic test_divn();
    do_reset(2'b01, 1, 0, 23, 4'd2, 0); run_case("R2", 200, 4, 1, 24);
    do_reset(2'b00, 1, 0, 4, 4'd2, 0);  run_case("R2", 16, 1, 1, 5);
  endtask

  task automatic test_zero();
    do_reset(2'b00, 1, 0, 0, 4'd2, 0); run_case("R3", 12, 1, 1, 1);
  endtask

  task automatic test_lock();
    do_reset(2'b00, 0, 1, 9, 4'd0, 0); run_case("R5", 400, 1, 2, 193);
    do_reset(2'b00, 0, 1, 9, 4'd2, 0); run_case("R5", 1650, 1, 2, 810);
    do_reset(2'b00, 0, 1, 9, 4'd9, 0); run_case("R5", 6, 1, 2, 1);
  endtask

  task automatic test_priority();
    do_reset(2'b00, 1, 1, 2, 4'd0, 0); run_case("R6", 12, 1, 1, 3);
  endtask

  task automatic test_inv_ignored();
    do_reset(2'b00, 1, 0, 2, 4'd2, 1); run_case("R9", 12, 1, 1, 3);
    do_reset(2'b00, 0, 0, 0, 4'd12, 1); run_case("R9", 6, 1, 0, 1);
  endtask

  task automatic test_low_rate(input logic [3:0] fc, input logic inv);
    do_reset(2'b01, 1, 0, 5, fc, inv);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk);
      check("R8", div_ce, !inv, i);
      ref_in = 1'b0;
      @(negedge clk);
      check("R8", div_ce, inv, i);
      @(negedge clk);
      check("R11", div_ce, 1'b0, i);
    end
  endtask

  task automatic test_reload();
    logic exp;
    do_reset(2'b00, 1, 0, 3, 4'd2, 0);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk);
      exp = (i == 1) || (i == 5) || (i >= 9);
      check("R4", div_ce, exp, i);
      ref_in = 1'b0;
      if (i == 6) div_n = '0;
      @(negedge clk);
    end
  endtask

  initial begin
    test_reset();
    test_stage_bypass();
    test_hf();
    test_divn();
    test_zero();
    test_lock();
    test_priority();
    test_inv_ignored();
    test_low_rate(4'd13, 1'b0);
    test_low_rate(4'd15, 1'b1);
    test_low_rate(4'd14, 1'b1);
    test_reload();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule